// File: doc/BRIEF.md
# SPI FIFO Level Interrupt Generator

This block holds the transmit and receive word queues that sit between a bus-side register port and the serial shift engine of an SPI host. Both queues are built over a fixed 16-byte store. The store is divided into 16, 8 or 4 entries depending on the selected word size. The block reports both fill levels in a status word. It raises a transmit interrupt and a receive interrupt whenever the threshold condition picked by a 2-bit mode holds. It also records three error conditions in sticky flags: receive overflow, transmit underrun and frame error. A fault interrupt fires for any flag whose enable bit is set.

The bus side pushes transmit words and pops receive words over valid/ready handshakes. A transfer happens on a clock edge where valid and ready are both high. The shift engine pops transmit words over a valid/ready handshake too. It delivers received words with a valid strobe only. The shifter cannot stall, so a word that finds the receive queue full is dropped and counted as an overflow. No output valid depends combinationally on a ready input. The bus may hold valid high across cycles while ready is low, and nothing is taken until ready rises. Software clears the error flags by pulsing the matching bits of a write-1-to-clear input. Dropping the enable flushes both queues.

Top module: `spi_fifo_irq`

## Requirements
- R1: Queue capacity in words is 16 for `cfg_wsize`=0 (8-bit), 8 for 1 (16-bit) and 4 for 2 (32-bit); the value 3 acts as 2. `tx_in_ready` is high only while the enable is set and the transmit level is below the capacity.
- R2: Both queues return words in the order they were accepted, with the data unchanged.
- R3: `status` carries the transmit level in bits 20:16 and the receive level in bits 28:24. Bit 5 is high when the receive queue is empty. Bit 6 is the overflow flag, bit 8 the underrun flag and bit 12 the frame-error flag. Every other bit is 0.
- R4: `irq_rx` follows `cfg_rx_mode`: 0 receive empty, 1 receive not empty, 2 receive level at least half the capacity, 3 receive level equal to the capacity.
- R5: `irq_tx` follows `cfg_tx_mode`: 0 transmit queue empty and `eng_busy` low, 1 transmit queue empty, 2 free slots at least half the capacity, 3 at least one free slot.
- R6: A received word that arrives while the receive queue is full, and is not popped in the same cycle, is dropped. It sets the overflow flag and leaves the stored words and the level unchanged.
- R7: When `cfg_framed` is high and the engine asserts `tx_out_ready` while the transmit queue is empty, the underrun flag is set. With `cfg_framed` low, the same request sets nothing.
- R8: A high `eng_frame_err` while enabled sets the frame-error flag.
- R9: `irq_fault` is high when an error flag is set together with its enable in `cfg_fault_en`, where bit 0 enables underrun, bit 1 overflow and bit 2 frame error.
- R10: The error flags persist until cleared. `err_clr` uses the same bit order as `cfg_fault_en`, and each set bit clears only its own flag. A set condition in the same cycle as a clear wins.
- R11: While the enable is low, both queues are flushed to level 0. Pushes are ignored, all valid and ready outputs are low, and `irq_tx` and `irq_rx` are low. The error flags are kept.
- R12: The word size changes only while the enable is low. The capacity that applies after re-enabling is the one for the new size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Block enable; low flushes both queues |
| cfg_wsize | input | 2 | Word size: 0 8-bit, 1 16-bit, 2 32-bit |
| cfg_rx_mode | input | 2 | Receive interrupt condition select |
| cfg_tx_mode | input | 2 | Transmit interrupt condition select |
| cfg_framed | input | 1 | Framed operation; enables underrun detection |
| cfg_fault_en | input | 3 | Fault enables: [0] underrun, [1] overflow, [2] frame error |
| err_clr | input | 3 | Write-1-to-clear pulses, same bit order as cfg_fault_en |
| tx_in_valid | input | 1 | Bus offers a transmit word |
| tx_in_ready | output | 1 | Transmit queue accepts a word |
| tx_in_data | input | 32 | Transmit word from the bus |
| tx_out_valid | output | 1 | Transmit word available to the engine |
| tx_out_ready | input | 1 | Engine takes a transmit word |
| tx_out_data | output | 32 | Oldest transmit word |
| rx_in_valid | input | 1 | Engine delivers a received word |
| rx_in_data | input | 32 | Received word from the engine |
| rx_out_valid | output | 1 | Received word available to the bus |
| rx_out_ready | input | 1 | Bus takes a received word |
| rx_out_data | output | 32 | Oldest received word |
| eng_busy | input | 1 | Shifter still holds a word in flight |
| eng_frame_err | input | 1 | Engine saw an extra frame sync |
| status | output | 32 | Levels, empty and error flags |
| irq_tx | output | 1 | Transmit threshold interrupt (level) |
| irq_rx | output | 1 | Receive threshold interrupt (level) |
| irq_fault | output | 1 | Enabled error present (level) |

## Verification
The assertions assume that `cfg_wsize` stays unchanged on every cycle where the enable is high in that cycle and in the one before. The capacity bound and the flush checks depend on that. The bench alters the word size only after it has dropped the enable and let one flushing edge pass. It re-enables only afterwards. The assertions also assume that the bus holds a push only while ready is high, or accepts that it is not taken. The bench always samples ready before it counts a push.

// File: rtl/fli_pkg.sv
package fli_pkg;
  localparam int unsigned STORE_BYTES = 16;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned LVL_W       = $clog2(STORE_BYTES + 1);

  typedef enum logic [1:0] {
    RXI_EMPTY = 2'd0,
    RXI_ANY   = 2'd1,
    RXI_HALF  = 2'd2,
    RXI_FULL  = 2'd3
  } rx_mode_e;

  typedef enum logic [1:0] {
    TXI_IDLE  = 2'd0,
    TXI_EMPTY = 2'd1,
    TXI_HALF  = 2'd2,
    TXI_ROOM  = 2'd3
  } tx_mode_e;

  // status bit positions (software decodes these)
  localparam int unsigned ST_RX_EMPTY = 5;
  localparam int unsigned ST_OVF      = 6;
  localparam int unsigned ST_UDR      = 8;
  localparam int unsigned ST_FRM      = 12;
  localparam int unsigned ST_TXL_LO   = 16;
  localparam int unsigned ST_RXL_LO   = 24;

  // error index order shared by enables, clears and flags
  localparam int unsigned E_UDR = 0;
  localparam int unsigned E_OVF = 1;
  localparam int unsigned E_FRM = 2;
  localparam int unsigned N_ERR = 3;

  function automatic logic [LVL_W-1:0] words_for(input logic [1:0] wsize);
    int unsigned bpw;
    case (wsize)
      2'd0:    bpw = 1;
      2'd1:    bpw = 2;
      default: bpw = 4;
    endcase
    return LVL_W'((STORE_BYTES + bpw - 1) / bpw);
  endfunction
endpackage

// File: rtl/fli_fifo.sv
module fli_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [LW-1:0] cap,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic          push_ok,
  output logic          empty,
  output logic [LW-1:0] level
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          pop_ok, at_cap;

  assign empty    = (level == '0);
  assign at_cap   = (level >= cap);
  assign pop_ok   = pop && !empty;
  assign push_ok  = push && (!at_cap || pop_ok);
  assign pop_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> level <= cap) else $error("level above capacity"); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && at_cap && push && !pop) |=> level == $past(level))
    else $error("push into full queue changed level"); // R6
endmodule

// File: rtl/fli_thresh.sv
module fli_thresh
  import fli_pkg::*;
(
  input  logic             enable,
  input  logic [LVL_W-1:0] cap,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [1:0]       rx_mode,
  input  logic [1:0]       tx_mode,
  input  logic             eng_busy,
  output logic             irq_tx,
  output logic             irq_rx
);
  logic [LVL_W-1:0] half, tx_free;
  logic             rx_hit, tx_hit;

  assign half    = cap >> 1;
  assign tx_free = cap - tx_level;

  always_comb begin
    case (rx_mode_e'(rx_mode))
      RXI_EMPTY: rx_hit = (rx_level == '0);
      RXI_ANY:   rx_hit = (rx_level != '0);
      RXI_HALF:  rx_hit = (rx_level >= half);
      default:   rx_hit = (rx_level == cap);
    endcase
    case (tx_mode_e'(tx_mode))
      TXI_IDLE:  tx_hit = (tx_level == '0) && !eng_busy;
      TXI_EMPTY: tx_hit = (tx_level == '0);
      TXI_HALF:  tx_hit = (tx_free >= half);
      default:   tx_hit = (tx_free != '0);
    endcase
  end

  assign irq_rx = enable && rx_hit;
  assign irq_tx = enable && tx_hit;
endmodule

// File: rtl/fli_err.sv
module fli_err
  import fli_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ERR-1:0] set,
  input  logic [N_ERR-1:0] clr,
  input  logic [N_ERR-1:0] en,
  output logic [N_ERR-1:0] flags,
  output logic             irq_fault
);
  for (genvar i = 0; i < N_ERR; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !clr[i]) |=> flags[i]) else $error("flag lost"); // R10
  end

  assign irq_fault = |(flags & en);
endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
  import fli_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_enable,
  input  logic [1:0]  cfg_wsize,
  input  logic [1:0]  cfg_rx_mode,
  input  logic [1:0]  cfg_tx_mode,
  input  logic        cfg_framed,
  input  logic [2:0]  cfg_fault_en,
  input  logic [2:0]  err_clr,
  input  logic        tx_in_valid,
  output logic        tx_in_ready,
  input  logic [31:0] tx_in_data,
  output logic        tx_out_valid,
  input  logic        tx_out_ready,
  output logic [31:0] tx_out_data,
  input  logic        rx_in_valid,
  input  logic [31:0] rx_in_data,
  output logic        rx_out_valid,
  input  logic        rx_out_ready,
  output logic [31:0] rx_out_data,
  input  logic        eng_busy,
  input  logic        eng_frame_err,
  output logic [31:0] status,
  output logic        irq_tx,
  output logic        irq_rx,
  output logic        irq_fault
);
  logic [LVL_W-1:0] cap, tx_level, rx_level;
  logic             flush, tx_empty, rx_empty;
  logic             tx_push_ok, rx_push_ok;
  logic [N_ERR-1:0] err_set, err_flags;

  assign cap   = words_for(cfg_wsize);
  assign flush = !cfg_enable;

  assign tx_in_ready  = cfg_enable && (tx_level < cap);
  assign tx_out_valid = cfg_enable && !tx_empty;
  assign rx_out_valid = cfg_enable && !rx_empty;

  fli_fifo #(.DW(WORD_W), .DEPTH(STORE_BYTES)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush), .cap(cap),
    .push(tx_in_valid && tx_in_ready), .push_data(tx_in_data),
    .pop(tx_out_valid && tx_out_ready), .pop_data(tx_out_data),
    .push_ok(tx_push_ok), .empty(tx_empty), .level(tx_level)
  );

  fli_fifo #(.DW(WORD_W), .DEPTH(STORE_BYTES)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush), .cap(cap),
    .push(cfg_enable && rx_in_valid), .push_data(rx_in_data),
    .pop(rx_out_valid && rx_out_ready), .pop_data(rx_out_data),
    .push_ok(rx_push_ok), .empty(rx_empty), .level(rx_level)
  );

  assign err_set[E_UDR] = cfg_enable && cfg_framed && tx_out_ready && tx_empty;
  assign err_set[E_OVF] = cfg_enable && rx_in_valid && !rx_push_ok;
  assign err_set[E_FRM] = cfg_enable && eng_frame_err;

  fli_err u_err (
    .clk(clk), .rst_n(rst_n), .set(err_set), .clr(err_clr),
    .en(cfg_fault_en), .flags(err_flags), .irq_fault(irq_fault)
  );

  fli_thresh u_thr (
    .enable(cfg_enable), .cap(cap), .tx_level(tx_level), .rx_level(rx_level),
    .rx_mode(cfg_rx_mode), .tx_mode(cfg_tx_mode), .eng_busy(eng_busy),
    .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  always_comb begin
    status = '0;
    status[ST_RX_EMPTY]            = rx_empty;
    status[ST_OVF]                 = err_flags[E_OVF];
    status[ST_UDR]                 = err_flags[E_UDR];
    status[ST_FRM]                 = err_flags[E_FRM];
    status[ST_TXL_LO +: LVL_W]     = tx_level;
    status[ST_RXL_LO +: LVL_W]     = rx_level;
  end

  AST_TX_READY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_in_ready |-> (tx_push_ok == tx_in_valid)) else $error("ready push refused"); // R1

  AST_WSIZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && $past(cfg_enable)) |-> $stable(cfg_wsize))
    else $error("word size changed while enabled"); // R12

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |-> !(irq_tx || irq_rx || tx_in_ready || tx_out_valid || rx_out_valid))
    else $error("activity while disabled"); // R11

  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_enable) |=> (tx_level == '0 && rx_level == '0))
    else $error("queues not flushed"); // R11

  AST_UDR_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[E_UDR]) |-> $past(cfg_framed))
    else $error("underrun outside framed mode"); // R7
endmodule

// File: tb/spi_fifo_irq_bench.sv
module spi_fifo_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic [1:0]  cfg_wsize = 2'd0, cfg_rx_mode = 2'd0, cfg_tx_mode = 2'd0;
  logic        cfg_framed = 1'b0;
  logic [2:0]  cfg_fault_en = 3'd0, err_clr = 3'd0;
  logic        tx_in_valid = 1'b0, tx_out_ready = 1'b0;
  logic        rx_in_valid = 1'b0, rx_out_ready = 1'b0;
  logic [31:0] tx_in_data = '0, rx_in_data = '0;
  logic        eng_busy = 1'b0, eng_frame_err = 1'b0;
  logic        tx_in_ready, tx_out_valid, rx_out_valid;
  logic [31:0] tx_out_data, rx_out_data, status;
  logic        irq_tx, irq_rx, irq_fault;
  int          n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  spi_fifo_irq u_spi_fifo_irq (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_wsize(cfg_wsize),
    .cfg_rx_mode(cfg_rx_mode), .cfg_tx_mode(cfg_tx_mode), .cfg_framed(cfg_framed),
    .cfg_fault_en(cfg_fault_en), .err_clr(err_clr),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data),
    .eng_busy(eng_busy), .eng_frame_err(eng_frame_err), .status(status),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_fault(irq_fault)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all helpers start and end at a falling edge
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic tx_push(input logic [31:0] d);
    tx_in_valid = 1'b1; tx_in_data = d; tick(); tx_in_valid = 1'b0;
  endtask

  task automatic rx_push(input logic [31:0] d);
    rx_in_valid = 1'b1; rx_in_data = d; tick(); rx_in_valid = 1'b0;
  endtask

  task automatic rx_pop(output logic [31:0] d);
    d = rx_out_data; rx_out_ready = 1'b1; tick(); rx_out_ready = 1'b0;
  endtask

  task automatic tx_pop(output logic [31:0] d);
    d = tx_out_data; tx_out_ready = 1'b1; tick(); tx_out_ready = 1'b0;
  endtask

  // R12: word size only moves with the enable low across a flushing edge
  task automatic restart(input logic [1:0] ws);
    cfg_enable = 1'b0; tick(); cfg_wsize = ws; tick(); cfg_enable = 1'b1; tick();
  endtask

  task automatic t_reset();
    chk("R3 reset status", status, 32'h20);
    chk("R11 reset irq_tx", {31'd0, irq_tx}, 0);
    chk("R11 reset irq_rx", {31'd0, irq_rx}, 0);
    chk("R11 reset tx_in_ready", {31'd0, tx_in_ready}, 0);
    chk("R9 reset irq_fault", {31'd0, irq_fault}, 0);
  endtask

  task automatic t_capacity(input logic [1:0] ws, input int exp);
    int n = 0;
    restart(ws);
    for (int i = 0; i < 20; i++) begin
      if (tx_in_ready) begin n++; tx_push(32'h100 + i); end
    end
    chk("R1 R12 capacity", n, exp);
    chk("R3 tx level field", {27'd0, status[20:16]}, exp);
    chk("R1 ready low at cap", {31'd0, tx_in_ready}, 0);
  endtask

  task automatic t_order();
    logic [31:0] d;
    restart(2'd0);
    for (int i = 0; i < 5; i++) tx_push(32'hA000 + 32'(i * 7));
    for (int i = 0; i < 5; i++) begin
      tx_pop(d); chk("R2 tx order", d, 32'hA000 + 32'(i * 7));
    end
    for (int i = 0; i < 5; i++) rx_push(32'hB000 + 32'(i * 3));
    chk("R3 rx level field", {27'd0, status[28:24]}, 5);
    chk("R3 rx empty low", {31'd0, status[5]}, 0);
    for (int i = 0; i < 5; i++) begin
      rx_pop(d); chk("R2 rx order", d, 32'hB000 + 32'(i * 3));
    end
    chk("R2 tx valid after drain", {31'd0, tx_out_valid}, 0);
  endtask

  task automatic rxm(input logic [1:0] m, input logic e, input string tag);
    cfg_rx_mode = m; #2; chk(tag, {31'd0, irq_rx}, {31'd0, e});
  endtask

  task automatic t_rx_irq();
    restart(2'd1);
    rxm(2'd0, 1, "R4 mode0 empty");
    rxm(2'd1, 0, "R4 mode1 empty");
    for (int i = 0; i < 3; i++) rx_push(32'(i));
    rxm(2'd1, 1, "R4 mode1 three");
    rxm(2'd2, 0, "R4 mode2 three");
    rx_push(32'd3);
    rxm(2'd2, 1, "R4 mode2 four");
    rxm(2'd3, 0, "R4 mode3 four");
    for (int i = 4; i < 8; i++) rx_push(32'(i));
    rxm(2'd3, 1, "R4 mode3 full");
    rxm(2'd0, 0, "R4 mode0 full");
  endtask

  task automatic txm(input logic [1:0] m, input logic e, input string tag);
    cfg_tx_mode = m; #2; chk(tag, {31'd0, irq_tx}, {31'd0, e});
  endtask

  task automatic t_tx_irq();
    restart(2'd1);
    eng_busy = 1'b1;
    txm(2'd0, 0, "R5 mode0 busy");
    txm(2'd1, 1, "R5 mode1 empty");
    eng_busy = 1'b0;
    txm(2'd0, 1, "R5 mode0 idle");
    for (int i = 0; i < 4; i++) tx_push(32'(i));
    txm(2'd2, 1, "R5 mode2 four free");
    txm(2'd1, 0, "R5 mode1 nonempty");
    tx_push(32'd4);
    txm(2'd2, 0, "R5 mode2 three free");
    txm(2'd3, 1, "R5 mode3 room");
    for (int i = 5; i < 8; i++) tx_push(32'(i));
    txm(2'd3, 0, "R5 mode3 full");
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    restart(2'd2);
    for (int i = 0; i < 4; i++) rx_push(32'hC0 + 32'(i));
    chk("R6 no flag before", {31'd0, status[6]}, 0);
    rx_push(32'hDEAD);
    chk("R6 overflow flag", {31'd0, status[6]}, 1);
    chk("R6 level kept", {27'd0, status[28:24]}, 4);
    for (int i = 0; i < 4; i++) begin
      rx_pop(d); chk("R6 contents kept", d, 32'hC0 + 32'(i));
    end
    chk("R6 flag sticky after drain", {31'd0, status[6]}, 1);
    err_clr = 3'b010; tick(); err_clr = 3'b000;
    chk("R10 overflow cleared", {31'd0, status[6]}, 0);
  endtask

  task automatic t_underrun_fault();
    restart(2'd0);
    tx_out_ready = 1'b1; tick(); tx_out_ready = 1'b0;
    chk("R7 unframed no underrun", {31'd0, status[8]}, 0);
    cfg_framed = 1'b1;
    tx_out_ready = 1'b1; tick(); tx_out_ready = 1'b0;
    cfg_framed = 1'b0;
    chk("R7 framed underrun", {31'd0, status[8]}, 1);
    chk("R9 masked fault", {31'd0, irq_fault}, 0);
    cfg_fault_en = 3'b110; #2;
    chk("R9 other enables", {31'd0, irq_fault}, 0);
    cfg_fault_en = 3'b001; #2;
    chk("R9 underrun enabled", {31'd0, irq_fault}, 1);
    eng_frame_err = 1'b1; tick(); eng_frame_err = 1'b0;
    chk("R8 frame flag", {31'd0, status[12]}, 1);
    err_clr = 3'b001; tick(); err_clr = 3'b000;
    chk("R10 underrun cleared", {31'd0, status[8]}, 0);
    chk("R10 frame kept", {31'd0, status[12]}, 1);
    chk("R9 fault drops", {31'd0, irq_fault}, 0);
    eng_frame_err = 1'b1; err_clr = 3'b100; tick();
    eng_frame_err = 1'b0; err_clr = 3'b000;
    chk("R10 set wins over clear", {31'd0, status[12]}, 1);
    cfg_fault_en = 3'b000;
  endtask

  task automatic t_disable();
    restart(2'd0);
    for (int i = 0; i < 3; i++) tx_push(32'(i));
    for (int i = 0; i < 2; i++) rx_push(32'(i));
    cfg_rx_mode = 2'd1; cfg_tx_mode = 2'd3;
    cfg_enable = 1'b0; tick();
    chk("R11 tx flushed", {27'd0, status[20:16]}, 0);
    chk("R11 rx flushed", {27'd0, status[28:24]}, 0);
    chk("R11 flag kept", {31'd0, status[12]}, 1);
    chk("R11 irqs low", {30'd0, irq_tx, irq_rx}, 0);
    chk("R11 handshakes low", {29'd0, tx_in_ready, tx_out_valid, rx_out_valid}, 0);
    tx_push(32'h55); rx_push(32'h66);
    cfg_enable = 1'b1; tick();
    chk("R11 pushes ignored", {22'd0, status[28:24], status[20:16]}, 0);
    err_clr = 3'b100; tick(); err_clr = 3'b000;
    chk("R10 frame cleared", status, 32'h20);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_capacity(2'd0, 16);
    t_capacity(2'd1, 8);
    t_capacity(2'd2, 4);
    t_capacity(2'd3, 4);
    t_order();
    t_rx_irq();
    t_tx_irq();
    t_overflow();
    t_underrun_fault();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule